// File: doc/BRIEF.md
# Shared RAM Zero-Fill and Check-Bypass Controller

This block sits beside a group of shared RAM blocks that several subsystems can master. Its 32-bit control word gives each block two things. The first is a test-enable bit that lets host writes skip check-bit generation. The second is a self-clearing trigger that starts a zero-fill of the whole block. Each fill word carries check bits computed over both the data and the address, so a later read with a wrong address decode shows up as an error and not as a valid zero.

A fill runs one word per clock from address 0 to the last address. When several blocks are triggered together, they are filled one after another in ascending block number. A per-block ownership input gates everything. A trigger or a bypass only takes effect for a block that this subsystem currently masters. The RAM write port is shared between the fill sequencer and a simple host write path. The fill has priority. The port is registered, so each word appears one clock after it is chosen.

Top module: `sram_init_ctrl`

## Requirements
- R1: After reset the control word reads 0, no block is busy, no done pulse is raised and the RAM write port is idle.
- R2: Readback places block n's test-enable bit at bit 2n+1. Bit 2n (the trigger) and bits 31..16 always read 0, whatever was written.
- R3: A register write with bit 2n set, for an owned and idle block n, fills addresses 0 to DEPTH-1 of block n in ascending order, one word per clock, with data 0. The first fill word appears on the port two clock edges after the edge that takes the register write.
- R4: Whenever the check lane is enabled, ram_chk[0] is the XOR of ram_wdata[15:0] and all ram_addr bits, and ram_chk[1] is the XOR of ram_wdata[31:16] and all ram_addr bits. Fill words always carry the enabled, correct check bits, even when that block's test bit is 1.
- R5: A 0 in a trigger bit starts nothing. A trigger for a block whose ownership input is 0 is ignored: no busy flag and no RAM write.
- R6: Blocks triggered in the same register write are filled one after another in ascending block number.
- R7: busy_o[n] is 1 from the edge that accepts the trigger until the edge that emits block n's last word. On that edge busy_o[n] falls and done_o[n] is high for exactly that one cycle, together with the write to address DEPTH-1.
- R8: A trigger for a block that is already busy is ignored. The block is filled exactly once.
- R9: A host write accepted in a cycle with no fill word appears on the RAM port after one clock edge. If the target block's test bit is 1 and the block is owned, the data goes out raw with ram_chk_en=0 and ram_chk=0. Otherwise the data goes out with ram_chk_en=1 and the R4 check bits.
- R10: A host write offered in a cycle in which the fill drives the port is dropped and never reaches the RAM port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 32 | Control word write value |
| reg_rd_data | output | 32 | Control word readback |
| own_i | input | NB | Per-block ownership, 1 = this subsystem masters the block |
| hst_we | input | 1 | Host RAM write request |
| hst_blk | input | log2(NB) | Host target block |
| hst_addr | input | AW | Host target address |
| hst_wdata | input | DW | Host write data |
| ram_we | output | 1 | RAM write strobe |
| ram_blk | output | log2(NB) | RAM block select |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | DW | RAM write data |
| ram_chk | output | 2 | Check-bit lane |
| ram_chk_en | output | 1 | Check lane valid (0 = bypass write) |
| busy_o | output | NB | Per-block fill in progress |
| done_o | output | NB | Per-block one-cycle fill-complete pulse |

## Verification
The bench triggers several blocks in one write and watches the fill order. A priority encoder pointing the wrong way would show up as a descending block sequence. It also re-triggers a block while that block is busy, where a design missing the busy guard would write the block twice. Triggers for unowned blocks and zero-valued triggers are checked for silence on the port. It fills a block whose test bit is set and expects correct check bits anyway. A design that let the bypass leak into the fill would emit words with the lane disabled. It also checks that host writes are dropped while the fill holds the port, and that bypass is applied only when the block is both in test mode and owned. The check bits are recomputed from address and data on every logged word, so parity that ignores the address or swaps the halves is caught.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned CTRL_W = 32;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_FILL = 1'b1
  } seq_st_e;
endpackage

// File: rtl/sic_chk.sv
module sic_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] addr_i,
  output logic [1:0]    chk_o
);
  localparam int unsigned HALF = DW / 2;

  logic addr_par;

  always_comb begin
    addr_par = ^addr_i;
    chk_o[0] = (^data_i[HALF-1:0]) ^ addr_par;
    chk_o[1] = (^data_i[DW-1:HALF]) ^ addr_par;
  end
endmodule

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int unsigned NB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [NB-1:0]     own_i,
  input  logic [NB-1:0]     busy_i,
  output logic [NB-1:0]     test_o,
  output logic [NB-1:0]     trig_o,
  output logic [CTRL_W-1:0] rd_data
);
  logic [NB-1:0] test_q;
  logic [NB-1:0] test_d;
  logic [NB-1:0] wr_test;
  logic [NB-1:0] wr_trig;

  for (genvar n = 0; n < NB; n++) begin : g_fld
    assign wr_test[n]        = wr_data[2*n+1];
    assign wr_trig[n]        = wr_data[2*n];
    assign rd_data[2*n+1]    = test_q[n];
    assign rd_data[2*n]      = 1'b0;
  end
  if (2*NB < CTRL_W) begin : g_rsv
    assign rd_data[CTRL_W-1:2*NB] = '0;
  end

  always_comb begin
    test_d = test_q;
    if (wr_en) test_d = wr_test;
    trig_o = (wr_en ? wr_trig : '0) & own_i & ~busy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_q <= '0;
    else        test_q <= test_d;
  end

  assign test_o = test_q;
endmodule

// File: rtl/sic_seq.sv
module sic_seq
  import sic_pkg::*;
#(
  parameter int unsigned NB    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned BW   = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] trig_i,
  output logic [NB-1:0] busy_o,
  output logic [NB-1:0] done_o,
  output logic          fill_we,
  output logic [BW-1:0] fill_blk,
  output logic [AW-1:0] fill_addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  seq_st_e       st_q, st_d;
  logic [NB-1:0] pend_q, pend_d;
  logic [NB-1:0] done_q, done_d;
  logic [BW-1:0] cur_q, cur_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [BW-1:0] low_blk;
  logic          low_hit;

  always_comb begin
    low_blk = '0;
    low_hit = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (pend_q[i] && !low_hit) begin
        low_blk = BW'(i);
        low_hit = 1'b1;
      end
    end
  end

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q | trig_i;
    done_d  = '0;
    cur_d   = cur_q;
    addr_d  = addr_q;
    fill_we = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (low_hit) begin
          st_d   = SEQ_FILL;
          cur_d  = low_blk;
          addr_d = '0;
        end
      end
      SEQ_FILL: begin
        fill_we = 1'b1;
        if (addr_q == LAST) begin
          pend_d[cur_q] = 1'b0;
          done_d[cur_q] = 1'b1;
          st_d          = SEQ_IDLE;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      pend_q <= '0;
      done_q <= '0;
      cur_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      done_q <= done_d;
      cur_q  <= cur_d;
      addr_q <= addr_d;
    end
  end

  assign busy_o    = pend_q;
  assign done_o    = done_q;
  assign fill_blk  = cur_q;
  assign fill_addr = addr_q;
endmodule

// File: rtl/sram_init_ctrl.sv
module sram_init_ctrl
  import sic_pkg::*;
#(
  parameter int unsigned NB    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned BW   = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [CTRL_W-1:0] reg_wr_data,
  output logic [CTRL_W-1:0] reg_rd_data,
  input  logic [NB-1:0]     own_i,
  input  logic              hst_we,
  input  logic [BW-1:0]     hst_blk,
  input  logic [AW-1:0]     hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  output logic              ram_we,
  output logic [BW-1:0]     ram_blk,
  output logic [AW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic [1:0]        ram_chk,
  output logic              ram_chk_en,
  output logic [NB-1:0]     busy_o,
  output logic [NB-1:0]     done_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [NB-1:0] test_en;
  logic [NB-1:0] trig;
  logic          fill_we;
  logic [BW-1:0] fill_blk;
  logic [AW-1:0] fill_addr;

  sic_regs #(.NB(NB)) u_regs (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .own_i   (own_i),
    .busy_i  (busy_o),
    .test_o  (test_en),
    .trig_o  (trig),
    .rd_data (reg_rd_data)
  );

  sic_seq #(.NB(NB), .DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .trig_i    (trig),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .fill_we   (fill_we),
    .fill_blk  (fill_blk),
    .fill_addr (fill_addr)
  );

  // port source select: fill wins, host only when the fill is silent
  logic          host_ok;
  logic          bypass;
  logic [BW-1:0] sel_blk;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_data;
  logic [1:0]    sel_chk;

  always_comb begin
    host_ok  = hst_we && !fill_we;
    sel_blk  = fill_we ? fill_blk  : hst_blk;
    sel_addr = fill_we ? fill_addr : hst_addr;
    sel_data = fill_we ? '0        : hst_wdata;
    bypass   = !fill_we && test_en[hst_blk] && own_i[hst_blk];
  end

  sic_chk #(.DW(DW), .AW(AW)) u_chk (
    .data_i (sel_data),
    .addr_i (sel_addr),
    .chk_o  (sel_chk)
  );

  logic          we_d;
  logic          we_q;
  logic          cen_d, cen_q;
  logic [BW-1:0] blk_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [1:0]    chk_d, chk_q;
  logic          load;

  always_comb begin
    we_d  = fill_we || host_ok;
    load  = we_d;
    cen_d = !bypass;
    chk_d = bypass ? 2'b00 : sel_chk;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) we_q <= 1'b0;
    else          we_q <= we_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      blk_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      chk_q  <= '0;
      cen_q  <= 1'b0;
    end else if (load) begin
      blk_q  <= sel_blk;
      addr_q <= sel_addr;
      data_q <= sel_data;
      chk_q  <= chk_d;
      cen_q  <= cen_d;
    end
  end

  assign ram_we     = we_q;
  assign ram_blk    = blk_q;
  assign ram_addr   = addr_q;
  assign ram_wdata  = data_q;
  assign ram_chk    = chk_q;
  assign ram_chk_en = cen_q;
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int unsigned NB    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned BW   = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic [31:0]   reg_wr_data,
  input logic [31:0]   reg_rd_data,
  input logic [NB-1:0] own_i,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic [1:0]    ram_chk,
  input logic          ram_chk_en,
  input logic [NB-1:0] busy_o,
  input logic [NB-1:0] done_o
);
  localparam int unsigned HALF = DW / 2;

  logic ap;
  assign ap = ^ram_addr;

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[31:2*NB] == '0);

  assert_chk_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_chk_en) |->
      (ram_chk[0] == ((^ram_wdata[HALF-1:0]) ^ ap)) &&
      (ram_chk[1] == ((^ram_wdata[DW-1:HALF]) ^ ap)));

  assert_bypass_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !ram_chk_en) |-> ram_chk == 2'b00);

  assert_done_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));

  assert_done_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o != '0) |-> (ram_we && ram_addr == AW'(DEPTH - 1)));

  for (genvar n = 0; n < NB; n++) begin : g_blk
    assert_trig_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_data[2*n] == 1'b0);

    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o[n] |-> (!busy_o[n] && $past(busy_o[n])));

    assert_start_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o[n]) |-> ($past(own_i[n]) && $past(reg_wr_en) && $past(reg_wr_data[2*n])));
  end
endmodule

bind sram_init_ctrl sic_checker #(.NB(NB), .DEPTH(DEPTH), .DW(DW)) u_sic_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .own_i       (own_i),
  .ram_we      (ram_we),
  .ram_addr    (ram_addr),
  .ram_wdata   (ram_wdata),
  .ram_chk     (ram_chk),
  .ram_chk_en  (ram_chk_en),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/tb_sram_init_ctrl.sv
module tb_sram_init_ctrl;
  localparam int NB    = 8;
  localparam int DEPTH = 16;
  localparam int DW    = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int BW    = $clog2(NB);
  localparam int LOGN  = 1024;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr_en;
  logic [31:0]   reg_wr_data;
  logic [31:0]   reg_rd_data;
  logic [NB-1:0] own_i;
  logic          hst_we;
  logic [BW-1:0] hst_blk;
  logic [AW-1:0] hst_addr;
  logic [DW-1:0] hst_wdata;
  logic          ram_we;
  logic [BW-1:0] ram_blk;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [1:0]    ram_chk;
  logic          ram_chk_en;
  logic [NB-1:0] busy_o;
  logic [NB-1:0] done_o;

  always #4 clk = ~clk;

  sram_init_ctrl #(.NB(NB), .DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .own_i(own_i),
    .hst_we(hst_we), .hst_blk(hst_blk), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .ram_we(ram_we), .ram_blk(ram_blk), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_chk(ram_chk), .ram_chk_en(ram_chk_en),
    .busy_o(busy_o), .done_o(done_o)
  );

  int total = 0;
  int bad   = 0;

  // write log, filled by the monitor only
  int            lg_n = 0;
  int            lg_blk  [LOGN];
  int            lg_addr [LOGN];
  logic [DW-1:0] lg_data [LOGN];
  logic [1:0]    lg_chk  [LOGN];
  logic          lg_en   [LOGN];
  logic [NB-1:0] lg_done [LOGN];

  always @(negedge clk) begin
    if (ram_we && lg_n < LOGN) begin
      lg_blk[lg_n]  = int'(ram_blk);
      lg_addr[lg_n] = int'(ram_addr);
      lg_data[lg_n] = ram_wdata;
      lg_chk[lg_n]  = ram_chk;
      lg_en[lg_n]   = ram_chk_en;
      lg_done[lg_n] = done_o;
      lg_n = lg_n + 1;
    end
  end

  function automatic logic [1:0] exp_chk(input logic [DW-1:0] d, input int a);
    logic [AW-1:0] aa;
    aa = AW'(a);
    return {(^d[DW-1:DW/2]) ^ (^aa), (^d[DW/2-1:0]) ^ (^aa)};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  task automatic reg_write(input logic [31:0] v);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_wr_data = v;
    @(negedge clk);
    reg_wr_en   = 1'b0;
    reg_wr_data = '0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 2000 && busy_o != '0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify_fill(input int base, input int blk, input string req);
    int errs = 0;
    int first = -1;
    for (int i = 0; i < DEPTH; i++) begin
      int k = base + i;
      logic [NB-1:0] dexp = (i == DEPTH - 1) ? NB'(1 << blk) : '0;
      if (lg_blk[k] != blk || lg_addr[k] != i || lg_data[k] != '0 || lg_en[k] != 1'b1 ||
          lg_chk[k] != exp_chk('0, i) || lg_done[k] != dexp) begin
        errs++;
        if (first < 0) first = i;
      end
    end
    check(errs == 0, req, first, -1);
  endtask

  // R1
  task automatic t_reset;
    check(reg_rd_data == 32'h0, "R1 readback", reg_rd_data, 0);
    check(busy_o == '0 && done_o == '0, "R1 busy/done", {busy_o, done_o}, 0);
    check(ram_we == 1'b0 && lg_n == 0, "R1 port idle", lg_n, 0);
  endtask

  // R2, R5: unowned triggers do nothing, trigger bits and reserved read 0
  task automatic t_readback;
    int base;
    own_i = '0;
    base  = lg_n;
    reg_write(32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    check(reg_rd_data == 32'h0000_AAAA, "R2 readback map", reg_rd_data, 32'h0000_AAAA);
    check(busy_o == '0 && lg_n == base, "R5 unowned trigger ignored", lg_n - base, 0);
    reg_write(32'h0);
    check(reg_rd_data == 32'h0, "R2 clear", reg_rd_data, 0);
  endtask

  // R5: zero trigger bits with ownership start nothing
  task automatic t_zero_trig;
    int base;
    own_i = '1;
    base  = lg_n;
    reg_write(32'h0000_0002);
    repeat (4) @(negedge clk);
    check(busy_o == '0 && lg_n == base, "R5 zero trigger no effect", lg_n - base, 0);
    check(reg_rd_data == 32'h0000_0002, "R2 test bit kept", reg_rd_data, 2);
    reg_write(32'h0);
  endtask

  // R3, R4, R7: single fill with latency, test bit set on the same block
  task automatic t_single;
    int base;
    own_i = '1;
    base  = lg_n;
    reg_write(32'h0000_00C0);  // block 3: test bit 7 and trigger bit 6
    check(busy_o == NB'(8) && ram_we == 1'b0, "R7 busy after trigger edge", busy_o, 8);
    @(negedge clk);
    check(ram_we == 1'b0, "R3 no word one edge later", ram_we, 0);
    @(negedge clk);
    check(ram_we && ram_blk == 3 && ram_addr == 0, "R3 first word two edges later",
          {ram_we, ram_blk, ram_addr}, {1'b1, 3'd3, 4'd0});
    wait_idle();
    check(lg_n - base == DEPTH, "R3 word count", lg_n - base, DEPTH);
    verify_fill(base, 3, "R4 R7 fill content with test bit set");
    check(reg_rd_data == 32'h0000_0080, "R2 trigger self-clears", reg_rd_data, 32'h80);
    reg_write(32'h0);
  endtask

  // R6: ascending order
  task automatic t_multi;
    int base;
    own_i = '1;
    base  = lg_n;
    reg_write(32'h0000_1404);  // blocks 1, 5, 6
    check(busy_o == NB'(8'h62), "R7 all three busy", busy_o, 8'h62);
    wait_idle();
    check(lg_n - base == 3 * DEPTH, "R6 word count", lg_n - base, 3 * DEPTH);
    verify_fill(base, 1, "R6 first block 1");
    verify_fill(base + DEPTH, 5, "R6 second block 5");
    verify_fill(base + 2 * DEPTH, 6, "R6 third block 6");
  endtask

  // R8: re-trigger while busy
  task automatic t_retrig;
    int base;
    own_i = '1;
    base  = lg_n;
    reg_write(32'h0000_0010);
    repeat (3) @(negedge clk);
    reg_write(32'h0000_0010);
    wait_idle();
    check(lg_n - base == DEPTH, "R8 filled once", lg_n - base, DEPTH);
    verify_fill(base, 2, "R8 fill content");
  endtask

  // R9: host path with bypass and normal check
  task automatic host_wr(input int blk, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_blk = BW'(blk); hst_addr = AW'(a); hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic t_host;
    logic [DW-1:0] d = 32'hA5A5_1234;
    own_i = '1;
    reg_write(32'h0000_0200);  // test bit for block 4
    host_wr(4, 5, d);
    check(ram_we && ram_blk == 4 && ram_addr == 5 && ram_wdata == d,
          "R9 host word one edge later", ram_wdata, d);
    check(ram_chk_en == 1'b0 && ram_chk == 2'b00, "R9 bypass raw", {ram_chk_en, ram_chk}, 0);
    own_i[4] = 1'b0;
    host_wr(4, 5, d);
    check(ram_chk_en == 1'b1 && ram_chk == exp_chk(d, 5), "R9 unowned keeps check",
          {ram_chk_en, ram_chk}, {1'b1, exp_chk(d, 5)});
    own_i[4] = 1'b1;
    reg_write(32'h0);
    host_wr(4, 9, d);
    check(ram_chk_en == 1'b1 && ram_chk == exp_chk(d, 9), "R9 R4 normal check",
          {ram_chk_en, ram_chk}, {1'b1, exp_chk(d, 9)});
    @(negedge clk);
    check(ram_we == 1'b0, "R9 single strobe", ram_we, 0);
  endtask

  // R10: host write during fill dropped
  task automatic t_host_drop;
    int base;
    int seen7 = 0;
    own_i = '1;
    base  = lg_n;
    reg_write(32'h0000_0001);
    repeat (4) @(negedge clk);
    host_wr(7, 3, 32'hFFFF_FFFF);
    wait_idle();
    for (int i = base; i < lg_n; i++) if (lg_blk[i] == 7) seen7++;
    check(seen7 == 0 && lg_n - base == DEPTH, "R10 host dropped during fill", seen7, 0);
    verify_fill(base, 0, "R10 fill intact");
  endtask

  initial begin
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wr_data = '0; own_i = '0;
    hst_we = 1'b0; hst_blk = '0; hst_addr = '0; hst_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_zero_trig();
    t_single();
    t_multi();
    t_retrig();
    t_host();
    t_host_drop();
    summary();
  end
endmodule